// File: doc/BRIEF.md
# RC-Timing Potentiometer Bank Scanner

The scanner turns the positions of up to fifteen knobs into 5-bit gain codes without an analog-to-digital converter. The knobs sit in four banks of four. Each knob charges a small capacitor through its wiper. The block empties all capacitors together, releases the sense lines and counts clock cycles until the selected line crosses the pad's logic threshold. The count, scaled down, becomes the knob's gain code. Knobs are visited one after another in a fixed order. Each visit follows the same pattern: all bank selects go low for a dead band, the target bank is selected, the shared lines are discharged and the charge is timed.

Every gain code is a level output that the consuming amplifiers read at any time. There is no data stream here, so no valid/ready handshake is used. Enable, bank selects and the sense-line drive are plain control pins, and the change flag is a plain status level that is refreshed once per sweep. The four knobs of the last bank act as preamp controls. For each of them the block also gives a 6-bit index into a 33-entry gain list.

Top module: `knob_scanner`

## Requirements
- R1: A sweep visits slots 0..15 in ascending order, where slot = 4*bank + line, and skips slot 11. Knob k (0..14) is slot k for k<11 and slot k+1 otherwise. `gain_codes[5k+4:5k]` holds knob k.
- R2: Before each knob, `bank_sel` is 4'b0000 for exactly 100 cycles. It then becomes one-hot with bit `bank` set, and stays so through discharge, timing and store. At no time is more than one bit high.
- R3: `sense_drive_low` is 4'b1111 for exactly 50 cycles per knob while the target bank is selected, and 4'b0000 at all other times (high impedance).
- R4: Sense inputs pass through a two-flop synchronizer. The first synchronized sample of the selected line after release is a fast-charge check: if it is high, the knob's code is 31 and no timing is done.
- R5: Otherwise each later synchronized sample that is low adds one to the count, and the first high sample ends the timing. The code is the count shifted right by two, clamped to 31. With the line going high D cycles after release (D>=2), the count is D-2.
- R6: If the count reaches 127 without a high sample, timing ends with count 127 and code 31.
- R7: A knob's register is written only when the new code differs from the stored one. `sweep_changed` is updated only at the end of a sweep: it is 1 if any register of that sweep was written, and 0 otherwise.
- R8: A new sweep starts only while `scan_en` is high. A sweep in progress always completes. With `scan_en` low after that, the sense lines are not driven and the bank selects stay low.
- R9: After the last knob of a sweep, all bank selects are driven low.
- R10: `preamp_index[6j+5:6j]` equals the code of knob 11+j plus one (range 1..32).
- R11: Reset sets all codes to 0 except knobs 11..14, which are set to 15 (index 16). Reset also clears `sweep_changed`, drives the bank selects low and releases the sense lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Permits new sweeps while high |
| sense_in | input | 4 | Pad input levels of the four sense lines |
| sense_drive_low | output | 4 | 1 = pull the line low, 0 = high impedance |
| bank_sel | output | 4 | Actively driven bank selects, one-hot or zero |
| gain_codes | output | 75 | Fifteen 5-bit gain codes, knob k at bits 5k+4:5k |
| preamp_index | output | 24 | Four 6-bit preamp list indices, code+1 |
| sweep_changed | output | 1 | Any code written during the last completed sweep |

## Verification
Two things can happen on the same edge: the write of the sweep's last knob (slot 15) and the publishing of `sweep_changed` for the whole sweep. The bench provokes this by repeating a sweep with identical knob delays, so the flag must drop to 0. It then changes only the last knob's delay, so the flag must come back as 1 purely from that final write. Fast-charge and saturation readings are provoked by delays of 0, 1 and above 129, and every code is compared with values computed from the delay.

// File: rtl/knob_pkg.sv
package knob_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD,
    ST_DISCH,
    ST_SETTLE,
    ST_TIME,
    ST_STORE
  } scan_state_t;
endpackage

// File: rtl/knob_sync.sv
module knob_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/knob_sequencer.sv
module knob_sequencer import knob_pkg::*; #(
  parameter int NUM_BANKS   = 4,
  parameter int LINES       = 4,
  parameter int UNUSED_SLOT = 11,
  parameter int DEAD_CYC    = 100,
  parameter int DISCH_CYC   = 50,
  parameter int SETTLE_CYC  = 2,
  localparam int NUM_SLOTS  = NUM_BANKS * LINES,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int LINE_W     = $clog2(LINES),
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              meas_done,
  output logic              timing,
  output logic              store_stb,
  output logic              last_store,
  output logic              sweep_start,
  output logic [SLOT_W-1:0] slot,
  output logic [LINE_W-1:0] line_idx,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [LINES-1:0]  drive_low
);
  localparam int MAX_WAIT = (DEAD_CYC > DISCH_CYC) ?
                            ((DEAD_CYC > SETTLE_CYC) ? DEAD_CYC : SETTLE_CYC) :
                            ((DISCH_CYC > SETTLE_CYC) ? DISCH_CYC : SETTLE_CYC);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);

  scan_state_t       state;
  logic [WAIT_W-1:0] wcnt;
  logic [SLOT_W:0]   inc_slot;
  logic [SLOT_W-1:0] next_slot;
  logic [BANK_W-1:0] bank_idx;
  logic              bank_active;

  assign inc_slot  = {1'b0, slot} + 1'b1;
  assign next_slot = (inc_slot == (SLOT_W+1)'(UNUSED_SLOT)) ?
                     SLOT_W'(inc_slot + 1'b1) : SLOT_W'(inc_slot);
  assign bank_idx  = BANK_W'(slot / SLOT_W'(LINES));
  assign line_idx  = LINE_W'(slot % SLOT_W'(LINES));

  assign bank_active = (state == ST_DISCH) || (state == ST_SETTLE) ||
                       (state == ST_TIME)  || (state == ST_STORE);
  assign bank_sel    = bank_active ? (NUM_BANKS'(1) << bank_idx) : '0;
  assign drive_low   = (state == ST_DISCH) ? '1 : '0;
  assign timing      = (state == ST_TIME);
  assign store_stb   = (state == ST_STORE);
  assign last_store  = store_stb && (slot == SLOT_W'(NUM_SLOTS-1));
  assign sweep_start = (state == ST_IDLE) && scan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
      slot  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (scan_en) begin
          slot  <= '0;
          wcnt  <= '0;
          state <= ST_DEAD;
        end
        ST_DEAD: if (wcnt == WAIT_W'(DEAD_CYC-1)) begin
          wcnt  <= '0;
          state <= ST_DISCH;
        end else wcnt <= wcnt + 1'b1;
        ST_DISCH: if (wcnt == WAIT_W'(DISCH_CYC-1)) begin
          wcnt  <= '0;
          state <= ST_SETTLE;
        end else wcnt <= wcnt + 1'b1;
        ST_SETTLE: if (wcnt == WAIT_W'(SETTLE_CYC-1)) begin
          wcnt  <= '0;
          state <= ST_TIME;
        end else wcnt <= wcnt + 1'b1;
        ST_TIME: if (meas_done) state <= ST_STORE;
        ST_STORE: begin
          if (slot == SLOT_W'(NUM_SLOTS-1)) state <= ST_IDLE;
          else begin
            slot  <= next_slot;
            state <= ST_DEAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: never two banks at once
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));
  // R2: discharge only begins after a cycle with every select low
  p_dead_before_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low[0]) |-> ($past(bank_sel) == '0));
  // R8: idle with enable low stays idle
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !scan_en) |=> (state == ST_IDLE));
  // R1: the spare slot is never visited
  p_skip_spare_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (slot != SLOT_W'(UNUSED_SLOT)));
endmodule

// File: rtl/knob_timer.sv
module knob_timer #(
  parameter int CNT_W  = 7,
  parameter int SHIFT  = 2,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sense,
  output logic              done,
  output logic [CODE_W-1:0] code
);
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  logic             first;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shifted;
  logic [CODE_W-1:0] scaled;

  assign shifted = cnt >> SHIFT;
  assign scaled  = (shifted > CNT_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : CODE_W'(shifted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first <= 1'b1;
      cnt   <= '0;
      done  <= 1'b0;
      code  <= '0;
    end else if (!active) begin
      first <= 1'b1;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      if (first) begin
        first <= 1'b0;
        if (sense) begin
          done <= 1'b1;
          code <= CODE_W'(MAX_CODE);
        end
      end else if (sense || cnt == CNT_W'(CNT_MAX)) begin
        done <= 1'b1;
        code <= scaled;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: threshold already crossed at the check gives the top code
  p_fast_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && first && !done && sense) |=> (done && code == CODE_W'(MAX_CODE)));
  // R6: running out of count gives the top code
  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !first && !done && !sense && cnt == CNT_W'(CNT_MAX))
      |=> (done && code == CODE_W'(MAX_CODE)));
  // R5: the counter only moves while a measurement runs
  p_cnt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> (cnt == '0));
endmodule

// File: rtl/knob_gain_bank.sv
module knob_gain_bank #(
  parameter int NUM_KNOBS   = 15,
  parameter int CODE_W      = 5,
  parameter int UNUSED_SLOT = 11,
  parameter int PRE_FIRST   = 11,
  parameter int PRE_RESET   = 15,
  parameter int SLOT_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_stb,
  input  logic                        wr_last,
  input  logic                        sweep_start,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [CODE_W-1:0]           wr_code,
  output logic [NUM_KNOBS*CODE_W-1:0] codes,
  output logic                        sweep_changed
);
  logic [NUM_KNOBS-1:0] diff;
  logic                 any_diff;
  logic                 pending;

  for (genvar k = 0; k < NUM_KNOBS; k++) begin : g_knob
    localparam int SLOT  = (k < UNUSED_SLOT) ? k : k + 1;
    localparam int RSTV  = (k >= PRE_FIRST) ? PRE_RESET : 0;
    logic [CODE_W-1:0] val;

    assign diff[k] = wr_stb && (wr_slot == SLOT_W'(SLOT)) && (wr_code != val);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= CODE_W'(RSTV);
      else if (diff[k]) val <= wr_code;
    end

    assign codes[k*CODE_W +: CODE_W] = val;
  end

  assign any_diff = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending       <= 1'b0;
      sweep_changed <= 1'b0;
    end else begin
      if (sweep_start) pending <= 1'b0;
      else if (wr_last) pending <= 1'b0;
      else if (any_diff) pending <= 1'b1;
      if (wr_last) sweep_changed <= pending | any_diff;
    end
  end

  // R7: codes move only on a store strobe
  p_hold_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(codes));
  // R7: the flag moves only when a sweep closes
  p_flag_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_last |=> $stable(sweep_changed));
endmodule

// File: rtl/knob_scanner.sv
module knob_scanner #(
  parameter int NUM_BANKS   = 4,
  parameter int LINES       = 4,
  parameter int UNUSED_SLOT = 11,
  parameter int DEAD_CYC    = 100,
  parameter int DISCH_CYC   = 50,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7,
  parameter int SHIFT       = 2,
  parameter int CODE_W      = 5,
  parameter int PRE_RESET   = 15,
  localparam int NUM_KNOBS  = NUM_BANKS * LINES - 1,
  localparam int NUM_PRE    = LINES,
  localparam int PRE_FIRST  = NUM_KNOBS - NUM_PRE
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_en,
  input  logic [LINES-1:0]              sense_in,
  output logic [LINES-1:0]              sense_drive_low,
  output logic [NUM_BANKS-1:0]          bank_sel,
  output logic [NUM_KNOBS*CODE_W-1:0]   gain_codes,
  output logic [NUM_PRE*(CODE_W+1)-1:0] preamp_index,
  output logic                          sweep_changed
);
  localparam int SLOT_W = $clog2(NUM_BANKS * LINES);
  localparam int LINE_W = $clog2(LINES);

  logic [LINES-1:0]  sense_sync;
  logic              timing, store_stb, last_store, sweep_start, meas_done;
  logic [SLOT_W-1:0] slot;
  logic [LINE_W-1:0] line_idx;
  logic [CODE_W-1:0] code;

  knob_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sense_in), .q(sense_sync)
  );

  knob_sequencer #(
    .NUM_BANKS(NUM_BANKS), .LINES(LINES), .UNUSED_SLOT(UNUSED_SLOT),
    .DEAD_CYC(DEAD_CYC), .DISCH_CYC(DISCH_CYC), .SETTLE_CYC(SYNC_STAGES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .meas_done(meas_done),
    .timing(timing), .store_stb(store_stb), .last_store(last_store),
    .sweep_start(sweep_start), .slot(slot), .line_idx(line_idx),
    .bank_sel(bank_sel), .drive_low(sense_drive_low)
  );

  knob_timer #(.CNT_W(CNT_W), .SHIFT(SHIFT), .CODE_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(timing), .sense(sense_sync[line_idx]),
    .done(meas_done), .code(code)
  );

  knob_gain_bank #(
    .NUM_KNOBS(NUM_KNOBS), .CODE_W(CODE_W), .UNUSED_SLOT(UNUSED_SLOT),
    .PRE_FIRST(PRE_FIRST), .PRE_RESET(PRE_RESET), .SLOT_W(SLOT_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(store_stb), .wr_last(last_store),
    .sweep_start(sweep_start), .wr_slot(slot), .wr_code(code),
    .codes(gain_codes), .sweep_changed(sweep_changed)
  );

  for (genvar j = 0; j < NUM_PRE; j++) begin : g_pre
    assign preamp_index[j*(CODE_W+1) +: (CODE_W+1)] =
      {1'b0, gain_codes[(PRE_FIRST+j)*CODE_W +: CODE_W]} + 1'b1;
  end
endmodule

// File: tb/test_knob_scanner.sv
`timescale 1ns/1ps
module test_knob_scanner;
  localparam int DEAD = 100;
  localparam int DISCH = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic [3:0]  sense_in;
  logic [3:0]  sense_drive_low;
  logic [3:0]  bank_sel;
  logic [74:0] gain_codes;
  logic [23:0] preamp_index;
  logic        sweep_changed;

  int checks = 0;
  int errors = 0;
  int dly [16];
  int model [15];
  int age = 0;
  int low_run = 0, dis_run = 0, knob_cnt = 0;
  logic [3:0] prev_bank = '0, prev_drive = '0;

  always #2.5 clk = ~clk;

  knob_scanner i_knob_scanner (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .sense_in(sense_in),
    .sense_drive_low(sense_drive_low), .bank_sel(bank_sel),
    .gain_codes(gain_codes), .preamp_index(preamp_index),
    .sweep_changed(sweep_changed)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // RC model: capacitor age counts cycles since the lines were released
  always @(negedge clk) begin
    if (sense_drive_low != 0) age <= 0;
    else if (age < 100000) age <= age + 1;
  end

  always_comb begin
    sense_in = '0;
    for (int b = 0; b < 4; b++)
      if (bank_sel == (4'b1 << b))
        for (int l = 0; l < 4; l++) sense_in[l] = (age >= dly[4*b+l]);
  end

  // Dead band and discharge width monitor (R2, R3)
  always @(negedge clk) begin
    if (rst_n) begin
      if (bank_sel == 0) low_run++;
      else begin
        if (prev_bank == 0 && (knob_cnt % 15) != 0)
          chk(low_run == DEAD, "R2 dead band length", low_run, DEAD);
        low_run = 0;
      end
      if (sense_drive_low != 0) begin
        chk(sense_drive_low == 4'hF && bank_sel != 0, "R3 all lines low with bank", sense_drive_low, 15);
        if (prev_drive == 0) knob_cnt++;
        dis_run++;
      end else if (prev_drive != 0) begin
        chk(dis_run == DISCH, "R3 discharge length", dis_run, DISCH);
        dis_run = 0;
      end
      prev_bank  = bank_sel;
      prev_drive = sense_drive_low;
    end
  end

  function automatic int exp_code(input int d);
    int r;
    if (d <= 1) return 31;          // R4 fast charge
    r = d - 2;                      // R5 count
    if (r > 127) r = 127;           // R6 saturation
    r = r >> 2;
    return (r > 31) ? 31 : r;
  endfunction

  function automatic int pat(input int p, input int s);
    case (p)
      0: return (s >= 12) ? 62 : 2 + (s % 4);  // equals reset codes
      1: return s * 9;
      2: return (s * 7 + 1) % 12;
      3: return 130 - s * 8;
      4: return (s == 15) ? 150 - s * 8 : 130 - s * 8;
      default: return 40 + s;
    endcase
  endfunction

  function automatic int slot_of(input int k);
    return (k < 11) ? k : k + 1;
  endfunction

  task automatic check_outputs(input bit exp_flag);
    for (int k = 0; k < 15; k++)
      chk(gain_codes[k*5 +: 5] == model[k], $sformatf("R5 code knob %0d", k),
          gain_codes[k*5 +: 5], model[k]);
    for (int j = 0; j < 4; j++)
      chk(preamp_index[j*6 +: 6] == model[11+j] + 1, "R10 preamp index",
          preamp_index[j*6 +: 6], model[11+j] + 1);
    chk(sweep_changed == exp_flag, "R7 sweep change flag", sweep_changed, exp_flag);
  endtask

  task automatic run_sweep(input int p, input bit drop_en);
    bit exp_flag = 0;
    for (int s = 0; s < 16; s++) dly[s] = pat(p, s);
    scan_en = 1'b1;
    for (int k = 0; k < 15; k++) begin
      do @(negedge clk); while (sense_drive_low == 0);
      chk(bank_sel == (4'b1 << (slot_of(k) / 4)), "R1 knob order / bank", bank_sel,
          1 << (slot_of(k) / 4));
      if (k == 0 && drop_en) scan_en = 1'b0;
      do @(negedge clk); while (sense_drive_low != 0);
    end
    do @(negedge clk); while (bank_sel != 0);
    chk(bank_sel == 0, "R9 selects low after sweep", bank_sel, 0);
    for (int k = 0; k < 15; k++) begin
      int c = exp_code(dly[slot_of(k)]);
      if (c != model[k]) exp_flag = 1;
      model[k] = c;
    end
    check_outputs(exp_flag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) dly[s] = 1000;
    for (int k = 0; k < 15; k++) model[k] = (k >= 11) ? 15 : 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(bank_sel == 0 && sense_drive_low == 0, "R11 reset pins", bank_sel, 0);
    check_outputs(1'b0);
    // R8 enable low: nothing starts
    repeat (300) @(negedge clk);
    chk(bank_sel == 0 && knob_cnt == 0, "R8 no sweep while disabled", knob_cnt, 0);

    run_sweep(0, 0);   // R7 codes equal reset values: no write
    run_sweep(1, 0);
    run_sweep(2, 0);   // R4 fast charge with delays 0 and 1
    run_sweep(3, 0);   // R6 saturation with long delays
    run_sweep(3, 0);   // R7 identical sweep: flag 0
    run_sweep(4, 0);   // R7 only the last knob changes: write and publish coincide
    run_sweep(1, 1);   // R8 enable dropped mid-sweep: sweep completes

    // R8 no new sweep; codes held although knobs moved
    for (int s = 0; s < 16; s++) dly[s] = pat(2, s);
    begin
      int busy = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (sense_drive_low != 0 || bank_sel != 0) busy++;
      end
      chk(busy == 0, "R8 idle after enable drop", busy, 0);
    end
    check_outputs(sweep_changed);
    run_sweep(5, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule